// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-Up Sequencer

This block drives a root port from power-down to an active link. After a start request it powers up the port and turns on the reference clock. It waits for the clock to settle, then pulses the endpoint reset with the hold and recovery delays it needs. Next it limits the link capability to first-generation speed and enables the training state machine. It then polls link status until the link reports up or the poll budget runs out.

On every poll that misses, the sequencer inspects two things: the PHY receiver status and the training state number. When training is parked in the recovery-lock state while the receiver reports no valid data, the speed change to the second generation has stalled. The sequencer then forces the receiver data and PLL overrides on for a timed interval and afterwards clears them again.

All register traffic goes to an external access engine through a level request / done-pulse port. Every delay is a multiple of one microsecond tick, derived from the clock by a parameter, so short values can be used in simulation. Results appear as one-cycle `link_ok` / `link_fail` pulses together with a phase code.

Top module: `link_bringup_seq`

States (code): IDLE 0, ENTRY 1, SETTLE 2, PERST_LO 3, PERST_HI 4, CAP_RD 5, CAP_WR 6, TRAIN_EN 7, STAT_RD 8, RX_RD 9, LTSSM_RD 10, OV_SET_RD 11, OV_SET_WR 12, OV_HOLD 13, OV_CLR_RD 14, OV_CLR_WR 15, POLL_WAIT 16, UP 17, FAIL 18.

Transitions:
- IDLE/UP/FAIL go to ENTRY on start.
- ENTRY goes to SETTLE.
- SETTLE, PERST_LO and PERST_HI each advance when their timer expires, in that order, to CAP_RD.
- CAP_RD goes to CAP_WR, then to TRAIN_EN, then to STAT_RD.
- STAT_RD goes to UP if the link is up, otherwise to RX_RD.
- RX_RD goes to LTSSM_RD.
- LTSSM_RD goes to OV_SET_RD if the transition is stuck, otherwise to POLL_WAIT.
- OV_SET_RD goes to OV_SET_WR, then OV_HOLD (timer), then OV_CLR_RD, then OV_CLR_WR, then POLL_WAIT.
- POLL_WAIT goes to FAIL when the budget is spent, otherwise back to STAT_RD.

## Requirements
- R1: After reset `state_code` is 0 (IDLE). In IDLE and ENTRY, pwr_down=1, refclk_en=0, ep_rst_n=0, ltssm_en=0, and no result pulse is given. `state_code` follows the numbering listed above.
- R2: From ENTRY (one cycle) the block releases the port: pwr_down=0 and refclk_en=1 from SETTLE onward. SETTLE lasts SETTLE_US*CLK_PER_US+1 cycles with ep_rst_n still 0.
- R3: ep_rst_n stays 0 through PERST_LO and goes to 1 from PERST_HI onward. PERST_LO and PERST_HI each last PERST_US*CLK_PER_US+1 cycles.
- R4: The block reads target 0 (link capability). It then writes to target 0 the read value with bits 3:0 replaced by 1, keeping all upper bits.
- R5: ltssm_en rises only after the capability write completes (state 7 onward) and stays 1 until the next start.
- R6: A status read (target 1) with bit 4 set and bit 29 clear moves the block to UP with a single-cycle link_ok pulse in its first UP cycle.
- R7: A status read with bit 4 set and bit 29 also set does not count as link up.
- R8: On a missed poll the block reads target 3 (receiver status), then target 2 (training state). It then waits POLL_US*CLK_PER_US+1 cycles in POLL_WAIT before the next status read.
- R9: After MAX_POLLS status reads without link up, the block enters FAIL with a single-cycle link_fail pulse in the first FAIL cycle.
- R10: A stall is detected when bits 5:0 of the training state equal 0x0D and receiver status bit 0 is 0; upper bits of the training state are ignored. The recovery is: read target 4, write that value OR 0x28, hold OV_HOLD for OVRD_US*CLK_PER_US+1 cycles, read target 4, write that value with bits 5 and 3 cleared.
- R11: No override traffic occurs if receiver bit 0 is 1, or if the training state is not 0x0D.
- R12: acc_req stays high, with acc_sel, acc_wr and acc_wdata unchanged, until acc_done. Read requests carry acc_wr=0 and acc_wdata=0.
- R13: start restarts the sequence from UP or FAIL through ENTRY. start has no effect in any other non-idle state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or restart) bring-up |
| pwr_down | output | 1 | Port test power-down |
| refclk_en | output | 1 | Reference clock enable |
| ep_rst_n | output | 1 | Endpoint reset, active low |
| ltssm_en | output | 1 | Training state machine enable |
| acc_req | output | 1 | Register access request (level) |
| acc_wr | output | 1 | 1 = write, 0 = read |
| acc_sel | output | 3 | Target: 0 link cap, 1 link status, 2 training state, 3 receiver status, 4 receiver override |
| acc_wdata | output | 32 | Write data |
| acc_done | input | 1 | One-cycle completion from access engine |
| acc_rdata | input | 32 | Read data, valid with acc_done |
| link_ok | output | 1 | Link-up pulse |
| link_fail | output | 1 | Timeout pulse |
| state_code | output | 5 | Current phase code |

## Verification
The bench runs three bring-up passes back to back:
- The first pass mixes three poll outcomes: in-training-while-up, a stalled speed change whose state byte carries extra upper bits, and a clean link-up. This separates the link-up qualifier, the 6-bit state compare and the full override recovery.
- The second pass never reaches link up and never stalls, so it reaches FAIL after exactly the poll budget. A stray start during the settle phase must leave the phase order and timing untouched.
- The third pass restarts from FAIL with state 0x0D but a valid receiver, which must not trigger recovery.

Each access is compared against a predicted queue, and each phase change is checked for order, dwell time and pin levels.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    typedef enum logic [4:0] {
        ST_IDLE      = 5'd0,
        ST_ENTRY     = 5'd1,
        ST_SETTLE    = 5'd2,
        ST_PERST_LO  = 5'd3,
        ST_PERST_HI  = 5'd4,
        ST_CAP_RD    = 5'd5,
        ST_CAP_WR    = 5'd6,
        ST_TRAIN_EN  = 5'd7,
        ST_STAT_RD   = 5'd8,
        ST_RX_RD     = 5'd9,
        ST_LTSSM_RD  = 5'd10,
        ST_OV_SET_RD = 5'd11,
        ST_OV_SET_WR = 5'd12,
        ST_OV_HOLD   = 5'd13,
        ST_OV_CLR_RD = 5'd14,
        ST_OV_CLR_WR = 5'd15,
        ST_POLL_WAIT = 5'd16,
        ST_UP        = 5'd17,
        ST_FAIL      = 5'd18
    } lbs_state_e;

    localparam logic [2:0] TGT_LINK_CAP  = 3'd0;
    localparam logic [2:0] TGT_LINK_STAT = 3'd1;
    localparam logic [2:0] TGT_TRAIN_ST  = 3'd2;
    localparam logic [2:0] TGT_RX_STAT   = 3'd3;
    localparam logic [2:0] TGT_RX_OVRD   = 3'd4;

    localparam int          STAT_UP_BIT    = 4;
    localparam int          STAT_TRAIN_BIT = 29;
    localparam logic [5:0]  STALL_STATE    = 6'h0D;
    localparam logic [31:0] OVRD_MASK      = 32'h0000_0028;
    localparam logic [31:0] CAP_SPEED_MASK = 32'h0000_000F;
    localparam logic [31:0] CAP_GEN1       = 32'h0000_0001;

endpackage

// File: rtl/lbs_tick_gen.sv
module lbs_tick_gen #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

endmodule

// File: rtl/lbs_delay_timer.sv
module lbs_delay_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    input  logic          tick,
    output logic          expired
);
    logic [TW-1:0] rem;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rem <= '0;
        else if (load)
            rem <= load_val;
        else if (tick && rem != '0)
            rem <= rem - 1'b1;
    end

    assign expired = (rem == '0);

    // R2: a countdown once at zero stays there until reloaded
    AST_TMR_REST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired); // R2

endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
    import lbs_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int SETTLE_US  = 50000,
    parameter int PERST_US   = 20000,
    parameter int POLL_US    = 10,
    parameter int OVRD_US    = 3000,
    parameter int MAX_POLLS  = 2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        pwr_down,
    output logic        refclk_en,
    output logic        ep_rst_n,
    output logic        ltssm_en,
    output logic        acc_req,
    output logic        acc_wr,
    output logic [2:0]  acc_sel,
    output logic [31:0] acc_wdata,
    input  logic        acc_done,
    input  logic [31:0] acc_rdata,
    output logic        link_ok,
    output logic        link_fail,
    output logic [4:0]  state_code
);
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAXD = imax(imax(SETTLE_US, PERST_US), imax(POLL_US, OVRD_US));
    localparam int TW   = $clog2(MAXD + 1);
    localparam int PW   = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);

    lbs_state_e    state, nxt;
    logic          tick, tmr_load, tmr_expired;
    logic [TW-1:0] tmr_val;
    logic [PW-1:0] poll_cnt;
    logic          rx_valid_q;
    logic          link_is_up, stalled;

    lbs_tick_gen #(.DIV(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_load),
        .tick  (tick)
    );

    lbs_delay_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tick),
        .expired  (tmr_expired)
    );

    assign link_is_up = acc_rdata[STAT_UP_BIT] && !acc_rdata[STAT_TRAIN_BIT];
    assign stalled    = !rx_valid_q && (acc_rdata[5:0] == STALL_STATE);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start) nxt = ST_ENTRY;
            ST_ENTRY:     nxt = ST_SETTLE;
            ST_SETTLE:    if (tmr_expired) nxt = ST_PERST_LO;
            ST_PERST_LO:  if (tmr_expired) nxt = ST_PERST_HI;
            ST_PERST_HI:  if (tmr_expired) nxt = ST_CAP_RD;
            ST_CAP_RD:    if (acc_done) nxt = ST_CAP_WR;
            ST_CAP_WR:    if (acc_done) nxt = ST_TRAIN_EN;
            ST_TRAIN_EN:  nxt = ST_STAT_RD;
            ST_STAT_RD:   if (acc_done) nxt = link_is_up ? ST_UP : ST_RX_RD;
            ST_RX_RD:     if (acc_done) nxt = ST_LTSSM_RD;
            ST_LTSSM_RD:  if (acc_done) nxt = stalled ? ST_OV_SET_RD : ST_POLL_WAIT;
            ST_OV_SET_RD: if (acc_done) nxt = ST_OV_SET_WR;
            ST_OV_SET_WR: if (acc_done) nxt = ST_OV_HOLD;
            ST_OV_HOLD:   if (tmr_expired) nxt = ST_OV_CLR_RD;
            ST_OV_CLR_RD: if (acc_done) nxt = ST_OV_CLR_WR;
            ST_OV_CLR_WR: if (acc_done) nxt = ST_POLL_WAIT;
            ST_POLL_WAIT: if (tmr_expired)
                              nxt = (poll_cnt == LAST_POLL) ? ST_FAIL : ST_STAT_RD;
            ST_UP:        if (start) nxt = ST_ENTRY;
            ST_FAIL:      if (start) nxt = ST_ENTRY;
            default:      nxt = ST_IDLE;
        endcase
    end

    // timer load on entry to a timed state
    always_comb begin
        tmr_val  = '0;
        tmr_load = 1'b0;
        if (nxt != state) begin
            unique case (nxt)
                ST_SETTLE:    begin tmr_load = 1'b1; tmr_val = TW'(SETTLE_US); end
                ST_PERST_LO,
                ST_PERST_HI:  begin tmr_load = 1'b1; tmr_val = TW'(PERST_US);  end
                ST_OV_HOLD:   begin tmr_load = 1'b1; tmr_val = TW'(OVRD_US);   end
                ST_POLL_WAIT: begin tmr_load = 1'b1; tmr_val = TW'(POLL_US);   end
                default:      begin tmr_load = 1'b0; tmr_val = '0;             end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // poll budget and captured receiver validity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_cnt   <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            if (state == ST_TRAIN_EN)
                poll_cnt <= '0;
            else if (state == ST_POLL_WAIT && nxt == ST_STAT_RD)
                poll_cnt <= poll_cnt + 1'b1;
            if (state == ST_RX_RD && acc_done)
                rx_valid_q <= acc_rdata[0];
        end
    end

    // registered Moore outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_down  <= 1'b1;
            refclk_en <= 1'b0;
            ep_rst_n  <= 1'b0;
            ltssm_en  <= 1'b0;
            acc_req   <= 1'b0;
            acc_wr    <= 1'b0;
            acc_sel   <= '0;
            acc_wdata <= '0;
            link_ok   <= 1'b0;
            link_fail <= 1'b0;
        end else begin
            pwr_down  <= (nxt == ST_IDLE) || (nxt == ST_ENTRY);
            refclk_en <= !((nxt == ST_IDLE) || (nxt == ST_ENTRY));
            ep_rst_n  <= (nxt >= ST_PERST_HI);
            ltssm_en  <= (nxt >= ST_TRAIN_EN);
            link_ok   <= (nxt == ST_UP)   && (state != ST_UP);
            link_fail <= (nxt == ST_FAIL) && (state != ST_FAIL);
            if (nxt != state) begin
                acc_req   <= 1'b1;
                acc_wr    <= 1'b0;
                acc_wdata <= '0;
                unique case (nxt)
                    ST_CAP_RD:    acc_sel <= TGT_LINK_CAP;
                    ST_CAP_WR: begin
                        acc_sel   <= TGT_LINK_CAP;
                        acc_wr    <= 1'b1;
                        acc_wdata <= (acc_rdata & ~CAP_SPEED_MASK) | CAP_GEN1;
                    end
                    ST_STAT_RD:   acc_sel <= TGT_LINK_STAT;
                    ST_RX_RD:     acc_sel <= TGT_RX_STAT;
                    ST_LTSSM_RD:  acc_sel <= TGT_TRAIN_ST;
                    ST_OV_SET_RD,
                    ST_OV_CLR_RD: acc_sel <= TGT_RX_OVRD;
                    ST_OV_SET_WR: begin
                        acc_sel   <= TGT_RX_OVRD;
                        acc_wr    <= 1'b1;
                        acc_wdata <= acc_rdata | OVRD_MASK;
                    end
                    ST_OV_CLR_WR: begin
                        acc_sel   <= TGT_RX_OVRD;
                        acc_wr    <= 1'b1;
                        acc_wdata <= acc_rdata & ~OVRD_MASK;
                    end
                    default: begin
                        acc_req <= 1'b0;
                        acc_sel <= '0;
                    end
                endcase
            end
        end
    end

    assign state_code = state;

    // R1: clock runs exactly when the port is powered
    AST_CLK_FOLLOWS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        refclk_en != pwr_down); // R1

    // R3: endpoint leaves reset only with a running clock
    AST_PERST_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        ep_rst_n |-> refclk_en); // R3

    // R5: training is enabled only with the endpoint out of reset
    AST_TRAIN_NEEDS_PERST: assert property (@(posedge clk) disable iff (!rst_n)
        ltssm_en |-> ep_rst_n); // R5

    // R6: result pulses are exclusive and last one cycle
    AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_ok && link_fail)); // R6
    AST_OK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        link_ok |=> !link_ok); // R6

    // R9: poll counter never passes the budget
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= LAST_POLL); // R9

    // R12: a pending request keeps its command stable until done
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !acc_done) |=> (acc_req && $stable(acc_sel)
                                    && $stable(acc_wr) && $stable(acc_wdata))); // R12

endmodule

// File: tb/tb_link_bringup_seq.sv
module tb_link_bringup_seq;

    localparam int DIV    = 2;
    localparam int SETTLE = 5;
    localparam int PERST  = 3;
    localparam int POLL   = 2;
    localparam int OVRD   = 4;
    localparam int MAXP   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        pwr_down, refclk_en, ep_rst_n, ltssm_en;
    logic        acc_req, acc_wr;
    logic [2:0]  acc_sel;
    logic [31:0] acc_wdata;
    logic        acc_done = 1'b0;
    logic [31:0] acc_rdata = '0;
    logic        link_ok, link_fail;
    logic [4:0]  state_code;

    always #5 clk = ~clk;

    link_bringup_seq #(
        .CLK_PER_US(DIV), .SETTLE_US(SETTLE), .PERST_US(PERST),
        .POLL_US(POLL), .OVRD_US(OVRD), .MAX_POLLS(MAXP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pwr_down(pwr_down), .refclk_en(refclk_en), .ep_rst_n(ep_rst_n),
        .ltssm_en(ltssm_en), .acc_req(acc_req), .acc_wr(acc_wr),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_done(acc_done),
        .acc_rdata(acc_rdata), .link_ok(link_ok), .link_fail(link_fail),
        .state_code(state_code)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [35:0] exp_acc[$];
    logic [4:0]  exp_st[$];
    logic [31:0] stat_q[$];
    logic [31:0] rx_q[$];
    logic [31:0] lt_q[$];
    logic [31:0] cap_reg  = '0;
    logic [31:0] ovrd_reg = '0;
    int          polls_done = 0;

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // access engine and scoreboard for register traffic (R4 R8 R10 R11 R12)
    initial begin
        forever begin
            @(negedge clk);
            if (acc_req) begin
                logic [35:0] got;
                logic [35:0] want;
                logic [31:0] resp;
                got = {acc_sel, acc_wr, acc_wdata};
                if (exp_acc.size() == 0) want = '1;
                else want = exp_acc.pop_front();
                check("R12 access", got, want);
                resp = '0;
                if (acc_wr) begin
                    if (acc_sel == 3'd0) cap_reg = acc_wdata;
                    if (acc_sel == 3'd4) ovrd_reg = acc_wdata;
                end else begin
                    case (acc_sel)
                        3'd0: resp = cap_reg;
                        3'd1: resp = (stat_q.size() != 0) ? stat_q.pop_front() : 32'h0;
                        3'd2: resp = (lt_q.size() != 0) ? lt_q.pop_front() : 32'h0;
                        3'd3: resp = (rx_q.size() != 0) ? rx_q.pop_front() : 32'h0;
                        3'd4: resp = ovrd_reg;
                        default: resp = 32'h0;
                    endcase
                end
                @(negedge clk);
                check("R12 req held", {35'd0, acc_req}, 36'd1);
                @(negedge clk);
                acc_rdata = resp;
                acc_done  = 1'b1;
                @(negedge clk);
                acc_done  = 1'b0;
                acc_rdata = '0;
            end
        end
    end

    function automatic int dwell(input logic [4:0] s);
        case (s)
            5'd2:        return SETTLE * DIV + 1;
            5'd3, 5'd4:  return PERST * DIV + 1;
            5'd13:       return OVRD * DIV + 1;
            5'd16:       return POLL * DIV + 1;
            default:     return -1;
        endcase
    endfunction

    // phase monitor: order, dwell, pin levels, result pulses
    initial begin
        logic [4:0] prev;
        int         enter;
        @(posedge rst_n);
        @(negedge clk);
        prev  = state_code;
        enter = cyc;
        forever begin
            @(negedge clk);
            if (state_code == 5'd17 && prev == 5'd17 && cyc == enter + 1)
                check("R6 ok pulse width", {35'd0, link_ok}, 36'd0);
            if (state_code != prev) begin
                logic [4:0] want;
                logic       pd;
                if (dwell(prev) > 0)
                    check("R2 R3 R8 R10 dwell", 36'(cyc - enter), 36'(dwell(prev)));
                want = (exp_st.size() != 0) ? exp_st.pop_front() : 5'h1F;
                check("R13 phase order", {31'd0, state_code}, {31'd0, want});
                pd = (state_code <= 5'd1);
                check("R1 R2 R3 R5 pins",
                      {32'd0, pwr_down, refclk_en, ep_rst_n, ltssm_en},
                      {32'd0, pd, !pd, state_code >= 5'd4, state_code >= 5'd7});
                check("R6 R9 pulses", {34'd0, link_ok, link_fail},
                      {34'd0, state_code == 5'd17, state_code == 5'd18});
                prev  = state_code;
                enter = cyc;
            end
        end
    end

    task automatic plan_prefix(input logic [31:0] cap);
        cap_reg = cap;
        polls_done = 0;
        for (int s = 1; s <= 7; s++) exp_st.push_back(5'(s));
        exp_acc.push_back({3'd0, 1'b0, 32'h0});
        exp_acc.push_back({3'd0, 1'b1, (cap & ~32'hF) | 32'h1});  // R4
    endtask

    task automatic plan_poll(input logic [31:0] st, input logic [31:0] rx, input logic [31:0] lt);
        exp_st.push_back(5'd8);
        exp_acc.push_back({3'd1, 1'b0, 32'h0});
        stat_q.push_back(st);
        if (st[4] && !st[29]) begin
            exp_st.push_back(5'd17);                         // R6
            return;
        end
        exp_st.push_back(5'd9);                              // R7 R8
        exp_acc.push_back({3'd3, 1'b0, 32'h0});
        rx_q.push_back(rx);
        exp_st.push_back(5'd10);
        exp_acc.push_back({3'd2, 1'b0, 32'h0});
        lt_q.push_back(lt);
        if (!rx[0] && lt[5:0] == 6'h0D) begin                // R10
            logic [31:0] set_v;
            set_v = ovrd_reg | 32'h28;
            exp_st.push_back(5'd11);
            exp_acc.push_back({3'd4, 1'b0, 32'h0});
            exp_st.push_back(5'd12);
            exp_acc.push_back({3'd4, 1'b1, set_v});
            exp_st.push_back(5'd13);
            exp_st.push_back(5'd14);
            exp_acc.push_back({3'd4, 1'b0, 32'h0});
            exp_st.push_back(5'd15);
            exp_acc.push_back({3'd4, 1'b1, set_v & ~32'h28});
        end                                                  // else R11
        exp_st.push_back(5'd16);
        polls_done++;
        if (polls_done == MAXP) exp_st.push_back(5'd18);     // R9
    endtask

    task automatic pulse_start;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain(input logic [4:0] final_st);
        while (exp_st.size() != 0 || exp_acc.size() != 0 || state_code != final_st)
            @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset state", {31'd0, state_code}, 36'd0);
        check("R1 reset pins", {30'd0, pwr_down, refclk_en, ep_rst_n, ltssm_en, link_ok, link_fail},
              {30'd0, 6'b100000});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // pass A: training-while-up, stall with high bits, then up
        ovrd_reg = 32'h0000_0101;
        plan_prefix(32'hABCD_1232);
        plan_poll(32'h2000_0010, 32'h1, 32'h11);   // R7
        plan_poll(32'h0, 32'h0, 32'hCD);           // R10 masked compare
        plan_poll(32'h0000_0010, 32'h0, 32'h0);    // R6
        pulse_start;
        drain(5'd17);
        check("R10 override cleared", {4'd0, ovrd_reg}, {4'd0, 32'h0000_0101});

        // pass B: restart from UP, ignored start mid-settle, budget runs out
        plan_prefix(32'h0000_00F3);
        plan_poll(32'h2000_0000, 32'h0, 32'h0C);
        plan_poll(32'h0, 32'h0, 32'h0C);
        plan_poll(32'h0, 32'h0, 32'h0C);
        plan_poll(32'h0, 32'h0, 32'h0C);
        pulse_start;                                // R13
        while (state_code != 5'd2) @(negedge clk);
        repeat (3) @(negedge clk);
        pulse_start;                                // R13 ignored
        drain(5'd18);
        check("R5 ltssm kept in FAIL", {35'd0, ltssm_en}, 36'd1);

        // pass C: restart from FAIL, state 0x0D with valid receiver
        plan_prefix(32'h0000_0005);
        plan_poll(32'h0, 32'h1, 32'h0D);            // R11
        plan_poll(32'h0000_0010, 32'h0, 32'h0);
        pulse_start;
        drain(5'd17);
        check("R4 cap written", {4'd0, cap_reg}, {4'd0, 32'h0000_0001});

        report;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog R13 actual=hung expected=finished");
        report;
        $finish;
    end

endmodule